// File: doc/BRIEF.md
# Multicycle Accumulator CPU Sequencer

This block is the control core of a small 8-bit accumulator processor. Program and data sit in one 16-byte memory, and every read or write of that memory goes through a memory address register. A fixed finite state machine, with no microcode store, steps each instruction through its phases. First the program counter is copied into the address register. Then the addressed byte goes into the instruction register while the program counter advances. After that come zero to three execute phases, chosen by the opcode.

The program counter is the only register clocked on the falling edge of the clock. Because of this, its increment lands in the middle of the decode phase and costs no separate cycle. Every other register updates on the rising edge. The block also holds thin stand-ins for the accumulator, the operand register, the adder/subtractor and the output latch. These are driven by the same strobes, so whole programs can run. A program is written into the memory through a load port while reset is held.

Top module: `seq_cpu_top`

## Requirements
- R1: Reset is synchronous and active high. While it is high, memory bytes may be written through the load port. The cycle after reset is released starts in the fetch-address phase, with program counter 0, accumulator 0, output 0 and the halt flag low.
- R2: The strobe word uses these bits: 13 pc_out, 12 pc_inc, 11 pc_load, 10 mar_in, 9 ram_out, 8 ram_in, 7 ir_in, 6 ir_out, 5 a_in, 4 a_out, 3 b_in, 2 alu_out, 1 alu_sub, 0 out_in. The fetch-address phase shows exactly 0x2400. The phase after it shows exactly 0x1280.
- R3: The program counter changes on the falling edge within the decode phase. At the start of that phase it still holds the old value, and after the falling edge it holds the old value plus one, modulo 16.
- R4: An instruction byte carries its opcode in bits 7:4 and its operand in bits 3:0. The opcodes are NOP=0, LDA=1, ADD=2, SUB=3, STA=4, LDI=5, JMP=6, OUT=14 and HLT=15. LDI puts the operand, zero-extended, into the accumulator. OUT copies the accumulator to the output.
- R5: LDA loads memory[operand] into the accumulator. ADD and SUB set the accumulator to the accumulator plus or minus memory[operand], modulo 256.
- R6: STA writes the accumulator into memory[operand], and a later LDA of that address reads it back.
- R7: JMP makes the operand the address of the next instruction fetched.
- R8: After HLT, the halt flag is high, the strobe word is zero, and the program counter and output stay unchanged until reset. Reset then restarts execution from address 0.
- R9: Opcodes 7 to 13 behave exactly like NOP and leave the accumulator and output unchanged.
- R10: Instructions take these numbers of cycles: NOP and unknown opcodes 2, LDI, JMP and OUT 3, LDA and STA 4, ADD and SUB 5. HLT raises the halt flag two cycles after its fetch begins.
- R11: At most one source drives the internal data bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the program counter uses its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Memory write enable for program loading, honoured only during reset |
| load_addr | input | 4 | Memory address for program loading |
| load_byte | input | 8 | Byte written during program loading |
| strobes | output | 14 | Control strobes of the current phase |
| pc | output | 4 | Program counter |
| acc | output | 8 | Accumulator |
| out_data | output | 8 | Output latch |
| halted | output | 1 | High while the machine is halted |

## Verification
The first cycles after reset are single-stepped, with samples taken after the rising edge and again after the falling edge. This separates a half-cycle program counter increment from a full-cycle one and confirms the exact strobe words. Several short programs then exercise different instructions: a load and add, a subtract that wraps below zero, a store followed by a read-back, a jump over an instruction that must be skipped, and a run of unknown opcodes. Each program is checked for its final accumulator, output and program counter, and for the exact cycle count up to halt, so a wrong phase count shows up even when the data comes out right. A long wait after halt checks that the machine stays silent, and a reset afterwards checks that it restarts cleanly.

// File: rtl/seq_cpu_pkg.sv
package seq_cpu_pkg;
    parameter int DATA_W = 8;
    parameter int ADDR_W = 4;
    localparam int OP_W  = DATA_W - ADDR_W;

    localparam logic [OP_W-1:0] OP_NOP = 4'd0;
    localparam logic [OP_W-1:0] OP_LDA = 4'd1;
    localparam logic [OP_W-1:0] OP_ADD = 4'd2;
    localparam logic [OP_W-1:0] OP_SUB = 4'd3;
    localparam logic [OP_W-1:0] OP_STA = 4'd4;
    localparam logic [OP_W-1:0] OP_LDI = 4'd5;
    localparam logic [OP_W-1:0] OP_JMP = 4'd6;
    localparam logic [OP_W-1:0] OP_OUT = 4'd14;
    localparam logic [OP_W-1:0] OP_HLT = 4'd15;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_OPADDR, S_LOADA, S_LOADB,
        S_ALU, S_STORE, S_LDI, S_JUMP, S_OUT, S_HALT
    } phase_e;

    // bit order is visible on the strobes port: pc_out is bit 13, out_in bit 0
    typedef struct packed {
        logic pc_out;
        logic pc_inc;
        logic pc_load;
        logic mar_in;
        logic ram_out;
        logic ram_in;
        logic ir_in;
        logic ir_out;
        logic a_in;
        logic a_out;
        logic b_in;
        logic alu_out;
        logic alu_sub;
        logic out_in;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/seq_cpu_fsm.sv
module seq_cpu_fsm
    import seq_cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] bus_op,
    input  logic [OP_W-1:0] ir_op,
    output ctl_t            ctl,
    output logic            halted
);
    typedef struct packed {
        phase_e phase;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ctl  = '0;
        unique case (st_q.phase)
            S_FETCH: begin
                ctl.pc_out = 1'b1;
                ctl.mar_in = 1'b1;
                st_d.phase = S_DECODE;
            end
            S_DECODE: begin
                ctl.ram_out = 1'b1;
                ctl.ir_in   = 1'b1;
                ctl.pc_inc  = 1'b1;
                // choose from the byte being latched into IR this cycle
                case (bus_op)
                    OP_LDA, OP_ADD, OP_SUB, OP_STA: st_d.phase = S_OPADDR;
                    OP_LDI: st_d.phase = S_LDI;
                    OP_JMP: st_d.phase = S_JUMP;
                    OP_OUT: st_d.phase = S_OUT;
                    OP_HLT: st_d.phase = S_HALT;
                    default: st_d.phase = S_FETCH;
                endcase
            end
            S_OPADDR: begin
                ctl.ir_out = 1'b1;
                ctl.mar_in = 1'b1;
                if (ir_op == OP_LDA)      st_d.phase = S_LOADA;
                else if (ir_op == OP_STA) st_d.phase = S_STORE;
                else                      st_d.phase = S_LOADB;
            end
            S_LOADA: begin
                ctl.ram_out = 1'b1;
                ctl.a_in    = 1'b1;
                st_d.phase  = S_FETCH;
            end
            S_LOADB: begin
                ctl.ram_out = 1'b1;
                ctl.b_in    = 1'b1;
                st_d.phase  = S_ALU;
            end
            S_ALU: begin
                ctl.alu_out = 1'b1;
                ctl.a_in    = 1'b1;
                ctl.alu_sub = (ir_op == OP_SUB);
                st_d.phase  = S_FETCH;
            end
            S_STORE: begin
                ctl.a_out  = 1'b1;
                ctl.ram_in = 1'b1;
                st_d.phase = S_FETCH;
            end
            S_LDI: begin
                ctl.ir_out = 1'b1;
                ctl.a_in   = 1'b1;
                st_d.phase = S_FETCH;
            end
            S_JUMP: begin
                ctl.ir_out  = 1'b1;
                ctl.pc_load = 1'b1;
                st_d.phase  = S_FETCH;
            end
            S_OUT: begin
                ctl.a_out  = 1'b1;
                ctl.out_in = 1'b1;
                st_d.phase = S_FETCH;
            end
            S_HALT: st_d.phase = S_HALT;
            default: st_d.phase = S_FETCH;
        endcase
        if (rst) st_d.phase = S_FETCH;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign halted = (st_q.phase == S_HALT);

    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == S_FETCH) |=> (st_q.phase == S_DECODE));

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == S_HALT) |=> (st_q.phase == S_HALT));
endmodule

// File: rtl/seq_cpu_pc.sv
module seq_cpu_pc
    import seq_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] pc_q
);
    logic [ADDR_W-1:0] pc_d;

    always_comb begin
        pc_d = pc_q;
        if (rst)       pc_d = '0;
        else if (load) pc_d = load_val;
        else if (inc)  pc_d = pc_q + 1'b1;
    end

    // falling edge: the increment lands halfway through the decode phase
    always_ff @(negedge clk) pc_q <= pc_d;

    a_r3_half_cycle_step: assert property (@(negedge clk) disable iff (rst)
        (inc && !load) |=> (pc_q == $past(pc_q) + 1'b1));

    a_r7_jump_lands: assert property (@(negedge clk) disable iff (rst)
        load |=> (pc_q == $past(load_val)));
endmodule

// File: rtl/seq_cpu_datapath.sv
module seq_cpu_datapath
    import seq_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_byte,
    output logic [DATA_W-1:0] bus,
    output logic [OP_W-1:0]   ir_op,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] out_data
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] outr;
    } regs_t;

    regs_t r_d, r_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] ram_rd;

    assign ram_rd  = mem_q[r_q.mar];
    assign alu_res = ctl.alu_sub ? (r_q.a - r_q.b) : (r_q.a + r_q.b);

    always_comb begin
        bus = '0;
        if (ctl.pc_out)       bus = {{(DATA_W-ADDR_W){1'b0}}, pc_val};
        else if (ctl.ram_out) bus = ram_rd;
        else if (ctl.ir_out)  bus = {{(DATA_W-ADDR_W){1'b0}}, r_q.ir[ADDR_W-1:0]};
        else if (ctl.a_out)   bus = r_q.a;
        else if (ctl.alu_out) bus = alu_res;
    end

    always_comb begin
        r_d = r_q;
        if (ctl.mar_in) r_d.mar  = bus[ADDR_W-1:0];
        if (ctl.ir_in)  r_d.ir   = bus;
        if (ctl.a_in)   r_d.a    = bus;
        if (ctl.b_in)   r_d.b    = bus;
        if (ctl.out_in) r_d.outr = bus;
        if (rst)        r_d      = '0;
    end

    always_ff @(posedge clk) r_q <= r_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            if (load_we) mem_q[load_addr] <= load_byte;
        end else if (ctl.ram_in) begin
            mem_q[r_q.mar] <= bus;
        end
    end

    assign ir_op    = r_q.ir[DATA_W-1:ADDR_W];
    assign acc      = r_q.a;
    assign out_data = r_q.outr;

    a_r11_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.pc_out, ctl.ram_out, ctl.ir_out, ctl.a_out, ctl.alu_out}));

    a_r5_alu_writeback: assert property (@(posedge clk) disable iff (rst)
        ctl.alu_out |=> (r_q.a == $past(ctl.alu_sub ? r_q.a - r_q.b : r_q.a + r_q.b)));

    a_r6_store_lands: assert property (@(posedge clk) disable iff (rst)
        ctl.ram_in |=> (mem_q[$past(r_q.mar)] == $past(r_q.a)));
endmodule

// File: rtl/seq_cpu_top.sv
module seq_cpu_top
    import seq_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_byte,
    output logic [CTL_W-1:0]  strobes,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] out_data,
    output logic              halted
);
    ctl_t              ctl;
    logic [DATA_W-1:0] bus;
    logic [OP_W-1:0]   ir_op;

    seq_cpu_fsm i_fsm (
        .clk    (clk),
        .rst    (rst),
        .bus_op (bus[DATA_W-1:ADDR_W]),
        .ir_op  (ir_op),
        .ctl    (ctl),
        .halted (halted)
    );

    seq_cpu_pc i_pc (
        .clk      (clk),
        .rst      (rst),
        .inc      (ctl.pc_inc),
        .load     (ctl.pc_load),
        .load_val (bus[ADDR_W-1:0]),
        .pc_q     (pc)
    );

    seq_cpu_datapath i_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .pc_val    (pc),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_byte (load_byte),
        .bus       (bus),
        .ir_op     (ir_op),
        .acc       (acc),
        .out_data  (out_data)
    );

    assign strobes = ctl;

    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (strobes == '0));

    a_r8_halt_frozen: assert property (@(posedge clk) disable iff (rst)
        (halted && $past(halted)) |-> ($stable(pc) && $stable(out_data)));

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc == '0 && out_data == '0 && !halted));
endmodule

// File: tb/test_seq_cpu_top.sv
`timescale 1ns/1ps
module test_seq_cpu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_we = 1'b0;
    logic [3:0]  load_addr = '0;
    logic [7:0]  load_byte = '0;
    logic [13:0] strobes;
    logic [3:0]  pc;
    logic [7:0]  acc;
    logic [7:0]  out_data;
    logic        halted;

    int total = 0;
    int bad   = 0;
    logic [7:0] img [16];

    always #2.5 clk = ~clk;

    seq_cpu_top i_seq_cpu_top (
        .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
        .load_byte(load_byte), .strobes(strobes), .pc(pc), .acc(acc),
        .out_data(out_data), .halted(halted)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
    endtask

    // holds reset, writes the image, releases reset just after a rising edge
    task automatic boot();
        @(posedge clk); #1;
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            load_we = 1'b1; load_addr = 4'(i); load_byte = img[i];
            @(posedge clk); #1;
        end
        load_we = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic run(output int cycles);
        cycles = 0;
        while (!halted && cycles < 300) begin
            @(posedge clk); #1;
            cycles++;
        end
    endtask

    task automatic t_reset_and_step();
        int n;
        clear_img();
        img[0] = 8'h55; img[1] = 8'hE0; img[2] = 8'hF0;
        boot();
        check("R1 pc", pc, 0);
        check("R1 acc", acc, 0);
        check("R1 out", out_data, 0);
        check("R1 halted", halted, 0);
        check("R2 fetch strobes", strobes, 14'h2400);
        @(posedge clk); #1;
        check("R2 decode strobes", strobes, 14'h1280);
        check("R3 pc before fall", pc, 0);
        @(negedge clk); #1;
        check("R3 pc after fall", pc, 1);
        run(n);
        check("R4 ldi/out value", out_data, 5);
        check("R10 ldi+out+hlt cycles", n + 1, 3 + 3 + 2);
    endtask

    task automatic t_load_add();
        int n;
        clear_img();
        img[0] = 8'h1E; img[1] = 8'h2F; img[2] = 8'hE0; img[3] = 8'hF0;
        img[14] = 8'h30; img[15] = 8'h12;
        boot();
        run(n);
        check("R5 lda+add acc", acc, 8'h42);
        check("R4 out copy", out_data, 8'h42);
        check("R10 lda+add cycles", n, 4 + 5 + 3 + 2);
        check("R3 pc after hlt", pc, 4);
    endtask

    task automatic t_sub_wrap();
        int n;
        clear_img();
        img[0] = 8'h53; img[1] = 8'h3F; img[2] = 8'hE0; img[3] = 8'hF0;
        img[15] = 8'h05;
        boot();
        run(n);
        check("R5 sub wrap", out_data, 8'hFE);
        check("R10 sub cycles", n, 3 + 5 + 3 + 2);
    endtask

    task automatic t_add_wrap();
        int n;
        clear_img();
        img[0] = 8'h1E; img[1] = 8'h2F; img[2] = 8'hF0;
        img[14] = 8'hF0; img[15] = 8'h20;
        boot();
        run(n);
        check("R5 add wrap", acc, 8'h10);
    endtask

    task automatic t_store();
        int n;
        clear_img();
        img[0] = 8'h59; img[1] = 8'h4C; img[2] = 8'h50; img[3] = 8'h1C;
        img[4] = 8'hE0; img[5] = 8'hF0;
        boot();
        run(n);
        check("R6 store readback", out_data, 9);
        check("R10 sta/lda cycles", n, 3 + 4 + 3 + 4 + 3 + 2);
    endtask

    task automatic t_jump();
        int n;
        clear_img();
        img[0] = 8'h51; img[1] = 8'h64; img[2] = 8'h57; img[3] = 8'hF0;
        img[4] = 8'hE0; img[5] = 8'hF0;
        boot();
        run(n);
        check("R7 jump skips ldi", acc, 1);
        check("R7 out after jump", out_data, 1);
        check("R7 pc after jump path", pc, 6);
        check("R10 jmp cycles", n, 3 + 3 + 3 + 2);
    endtask

    task automatic t_unknown();
        int n;
        clear_img();
        img[0] = 8'h75; img[1] = 8'h8A; img[2] = 8'hD3; img[3] = 8'h00;
        img[4] = 8'h52; img[5] = 8'hE0; img[6] = 8'hF0;
        boot();
        run(n);
        check("R9 unknown as nop acc", acc, 2);
        check("R9 unknown cycles", n, 2 * 4 + 3 + 3 + 2);
    endtask

    task automatic t_halt_hold();
        int n;
        int quiet_bad = 0;
        clear_img();
        img[0] = 8'h57; img[1] = 8'hE0; img[2] = 8'hF0; img[3] = 8'h53;
        boot();
        run(n);
        check("R8 halted", halted, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (strobes != 0 || pc != 3 || out_data != 7 || !halted) quiet_bad++;
        end
        check("R8 quiet while halted", quiet_bad, 0);
        boot();
        check("R8 restart pc", pc, 0);
        check("R8 restart halted", halted, 0);
        check("R8 restart strobes", strobes, 14'h2400);
        run(n);
        check("R8 reruns program", out_data, 7);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_and_step();
        t_load_add();
        t_sub_wrap();
        t_add_wrap();
        t_store();
        t_jump();
        t_unknown();
        t_halt_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule